// File: doc/BRIEF.md
# Teletext Request Window Generator

On every video line that carries teletext, this block raises a data-request strobe for a bounded stretch of pixel clocks. While the strobe is high it also counts the teletext bits it asks for. An 8-bit control word sets two 4-bit offsets, one that delays the leading edge and one that pulls in the trailing edge. Both are counted in pixel clocks from fixed nominal positions, which are measured from a line-start pulse.

A bit-rate pulse is made inside the block by a fractional accumulator. By default it runs at 37/72 of the pixel clock. The accumulator restarts whenever the strobe is low, so the bit count of a window depends only on the window's length. With both offsets at zero, the window is 701 clocks long and yields 360 bits.

A non-zero trailing offset shortens the window below that default, which means fewer bits are requested. A zero trailing offset makes the trailing edge follow the leading offset, so the window length stays fixed. Control writes land in a shadow copy, and that copy is adopted at the next line start. This keeps a write from disturbing the line that is already running.

Top module: `ttx_req_win`

## Requirements
- R1: The control word splits into two fields. Bits 7:4 hold the leading offset r and bits 3:0 hold the trailing offset f, each from 0 to 15 clocks.
- R2: Call the edge that samples line_start E0. On an enabled line, ttx_req goes high at edge E0+RISE_BASE+r+1, where RISE_BASE defaults to 40.
- R3: With r=0 and f=0, ttx_req stays high for 701 clocks and ttx_bits ends at 360. ttx_bits never exceeds 360.
- R4: With f non-zero, the trailing edge sits at the fixed position RISE_BASE+701-f. The window is then 701-f-r clocks long, giving fewer than 360 bits.
- R5: With f=0, the trailing edge moves with r. The window is 701 clocks and yields 360 bits for every r.
- R6: ttx_line_en is sampled only at line start. A line that starts with ttx_line_en low has no strobe and a bit count of 0, and a later change of ttx_line_en does not affect the current line.
- R7: ttx_bits is 0 on the clock after a line start. It then rises by at most one per clock, and only on clocks when the strobe is high. After n strobe-high clocks it reads floor(n*37/72). It holds its value until the next line start.
- R8: A write in the middle of a line changes nothing until the next line start. A write in the same cycle as line_start applies to the line that begins in that cycle.
- R9: While reset is asserted, and after reset until the first line start, ttx_req is low and ttx_bits is 0.
- R10: A line start that arrives during a window drops ttx_req on the next clock and restarts the line timing from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_start | input | 1 | One-clock pulse that marks the start of a line |
| ttx_line_en | input | 1 | High if the line that is starting carries teletext |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 8 | Control word: leading offset in bits 7:4, trailing offset in bits 3:0 |
| ttx_req | output | 1 | Teletext data-request strobe |
| ttx_bits | output | 9 | Number of bits requested so far in the current line |

## Verification
The two functions that can meet in one cycle are a control write and the adoption of that write at line start. The other collision is a line start landing while a window is still open. The bench provokes the first by raising cfg_wr and line_start together, then requires the leading edge of that same line to move to the new offset. It provokes the second by pulsing line_start in the middle of a window. It then requires the strobe and the count to be low on the following clock, and a full window of the expected length to follow.

// File: rtl/ttx_req_pkg.sv
package ttx_req_pkg;

  localparam int FIELD_W = 4;
  localparam int CFG_W   = 2 * FIELD_W;

  // Leading offset occupies the upper nibble, trailing offset the lower one.
  typedef struct packed {
    logic [FIELD_W-1:0] rise;
    logic [FIELD_W-1:0] fall;
  } ttx_cfg_t;

  localparam int FIELD_MAX = (1 << FIELD_W) - 1;

endpackage

// File: rtl/ttx_req_rst_sync.sv
module ttx_req_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync
);

  logic [STAGES-1:0] shr_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shr_q <= 1'b0;
        else        shr_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shr_q <= '0;
        else        shr_q <= {shr_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync = shr_q[STAGES-1];

endmodule

// File: rtl/ttx_req_cfg.sv
module ttx_req_cfg
  import ttx_req_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             line_en_in,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output ttx_cfg_t         cfg_act,
  output logic             line_en_q
);

  ttx_cfg_t shadow_q, shadow_d;
  ttx_cfg_t act_q, act_d;
  logic     en_d;
  logic     shadow_ce, act_ce;

  // Shadow copy takes writes at any time.
  assign shadow_ce = cfg_wr;
  assign shadow_d  = ttx_cfg_t'(cfg_wdata);

  // Active copy is refreshed only at line start; a write in that same
  // cycle bypasses the shadow so it governs the line now beginning.
  assign act_ce = line_start;

  always_comb begin
    act_d = shadow_q;
    if (cfg_wr) act_d = ttx_cfg_t'(cfg_wdata);
    en_d = line_en_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      act_q     <= '0;
      line_en_q <= 1'b0;
    end else begin
      if (shadow_ce) shadow_q <= shadow_d;
      if (act_ce) begin
        act_q     <= act_d;
        line_en_q <= en_d;
      end
    end
  end

  assign cfg_act = act_q;

endmodule

// File: rtl/ttx_req_timer.sv
module ttx_req_timer
  import ttx_req_pkg::*;
#(
  parameter int RISE_BASE = 40,
  parameter int WIN_CLKS  = 701,
  parameter int POS_W     = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line_start,
  input  logic     line_en_q,
  input  ttx_cfg_t cfg_act,
  output logic     req
);

  localparam logic [POS_W-1:0] POS_IDLE = '1;
  localparam logic [POS_W-1:0] BASE_R   = POS_W'(RISE_BASE);
  localparam logic [POS_W-1:0] BASE_F   = POS_W'(RISE_BASE + WIN_CLKS);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [POS_W-1:0] rise_pos, fall_pos;
  logic             pos_ce;
  logic             req_q, req_d;

  // Edge positions measured from the line-start pulse.
  always_comb begin
    rise_pos = BASE_R + POS_W'(cfg_act.rise);
    if (cfg_act.fall == '0) fall_pos = BASE_F + POS_W'(cfg_act.rise);
    else                    fall_pos = BASE_F - POS_W'(cfg_act.fall);
  end

  // Position counter: restarts at line start, parks at the idle value.
  assign pos_ce = line_start | (pos_q != POS_IDLE);

  always_comb begin
    if (line_start) pos_d = '0;
    else            pos_d = pos_q + 1'b1;
  end

  // Strobe next state.
  always_comb begin
    req_d = req_q;
    if (line_start)                        req_d = 1'b0;
    else if (pos_q == fall_pos)            req_d = 1'b0;
    else if (pos_q == rise_pos && line_en_q) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= POS_IDLE;
      req_q <= 1'b0;
    end else begin
      if (pos_ce) pos_q <= pos_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;

endmodule

// File: rtl/ttx_req_bitcnt.sv
module ttx_req_bitcnt #(
  parameter int BIT_NUM  = 37,
  parameter int BIT_DEN  = 72,
  parameter int WIN_BITS = 360,
  parameter int CNT_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             req,
  output logic [CNT_W-1:0] bits
);

  localparam int ACC_W = $clog2(BIT_NUM + BIT_DEN);
  localparam logic [ACC_W-1:0] NUM_C = ACC_W'(BIT_NUM);
  localparam logic [ACC_W-1:0] DEN_C = ACC_W'(BIT_DEN);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN_BITS);

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit;
  logic             cnt_ce;

  // Fractional bit-rate pulse, only meaningful while the strobe is high.
  always_comb begin
    sum = acc_q + NUM_C;
    hit = req && (sum >= DEN_C);
    if (line_start || !req) acc_d = '0;
    else if (hit)           acc_d = sum - DEN_C;
    else                    acc_d = sum;
  end

  assign cnt_ce = line_start | (hit && cnt_q < CNT_MAX);

  always_comb begin
    if (line_start) cnt_d = '0;
    else            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      if (cnt_ce) cnt_q <= cnt_d;
    end
  end

  assign bits = cnt_q;

endmodule

// File: rtl/ttx_req_win.sv
module ttx_req_win
  import ttx_req_pkg::*;
#(
  parameter int RISE_BASE   = 40,
  parameter int WIN_CLKS    = 701,
  parameter int WIN_BITS    = 360,
  parameter int BIT_NUM     = 37,
  parameter int BIT_DEN     = 72,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic       ttx_line_en,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic       ttx_req,
  output logic [8:0] ttx_bits
);

  localparam int CNT_W   = $clog2(WIN_BITS + 1);
  localparam int POS_TOP = RISE_BASE + FIELD_MAX + WIN_CLKS + 1;
  localparam int POS_W   = $clog2(POS_TOP + 1);

  logic             rst_sync;
  ttx_cfg_t         cfg_act;
  logic             line_en_q;
  logic [CNT_W-1:0] bits_w;

  ttx_req_rst_sync #(.STAGES(SYNC_STAGES)) rst_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_sync (rst_sync)
  );

  ttx_req_cfg cfg_i (
    .clk        (clk),
    .rst_n      (rst_sync),
    .line_start (line_start),
    .line_en_in (ttx_line_en),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_act    (cfg_act),
    .line_en_q  (line_en_q)
  );

  ttx_req_timer #(
    .RISE_BASE (RISE_BASE),
    .WIN_CLKS  (WIN_CLKS),
    .POS_W     (POS_W)
  ) tmr_i (
    .clk        (clk),
    .rst_n      (rst_sync),
    .line_start (line_start),
    .line_en_q  (line_en_q),
    .cfg_act    (cfg_act),
    .req        (ttx_req)
  );

  ttx_req_bitcnt #(
    .BIT_NUM  (BIT_NUM),
    .BIT_DEN  (BIT_DEN),
    .WIN_BITS (WIN_BITS),
    .CNT_W    (CNT_W)
  ) cnt_i (
    .clk        (clk),
    .rst_n      (rst_sync),
    .line_start (line_start),
    .req        (ttx_req),
    .bits       (bits_w)
  );

  assign ttx_bits = 9'(bits_w);

endmodule

// File: rtl/ttx_req_win_chk.sv
module ttx_req_win_chk #(
  parameter int WIN_BITS = 360
) (
  input logic       clk,
  input logic       rst_sync,
  input logic       line_start,
  input logic       line_en_q,
  input logic       ttx_req,
  input logic [8:0] ttx_bits
);

  AST_START_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_sync)
    line_start |=> !ttx_req); // R10

  AST_START_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_sync)
    line_start |=> (ttx_bits == 9'd0)); // R7

  AST_BITS_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_sync)
    !line_start |=> (ttx_bits == $past(ttx_bits) || ttx_bits == $past(ttx_bits) + 9'd1)); // R7

  AST_BITS_HOLD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_sync)
    (!line_start && !ttx_req) |=> $stable(ttx_bits)); // R7

  AST_BITS_CEILING: assert property (@(posedge clk) disable iff (!rst_sync)
    ttx_bits <= 9'(WIN_BITS)); // R3

  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_sync)
    !line_en_q |-> !ttx_req); // R6

endmodule

bind ttx_req_win ttx_req_win_chk #(.WIN_BITS(WIN_BITS)) chk_i (
  .clk        (clk),
  .rst_sync   (rst_sync),
  .line_start (line_start),
  .line_en_q  (line_en_q),
  .ttx_req    (ttx_req),
  .ttx_bits   (ttx_bits)
);

// File: tb/ttx_req_win_tb_top.sv
module ttx_req_win_tb_top;

  localparam int RISE_BASE = 40;
  localparam int WIN_CLKS  = 701;
  localparam int NUM       = 37;
  localparam int DEN       = 72;
  localparam int LINE      = 800;

  // {rise[3:0], fall[3:0], enable}
  localparam logic [8:0] VEC [8] = '{
    {4'd0,  4'd0,  1'b1},
    {4'd5,  4'd0,  1'b1},
    {4'd15, 4'd0,  1'b1},
    {4'd0,  4'd1,  1'b1},
    {4'd0,  4'd15, 1'b1},
    {4'd15, 4'd15, 1'b1},
    {4'd7,  4'd3,  1'b1},
    {4'd3,  4'd0,  1'b0}
  };

  logic       clk;
  logic       rst_n;
  logic       line_start;
  logic       ttx_line_en;
  logic       cfg_wr;
  logic [7:0] cfg_wdata;
  logic       ttx_req;
  logic [8:0] ttx_bits;

  int n_tests;
  int n_fail;

  ttx_req_win dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .ttx_line_en (ttx_line_en),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .ttx_req     (ttx_req),
    .ttx_bits    (ttx_bits)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_len(int r, int f);
    return (f == 0) ? WIN_CLKS : WIN_CLKS - f - r;
  endfunction

  function automatic int exp_bits(int n);
    return (n * NUM) / DEN;
  endfunction

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    cfg_wr    = 1'b1;
    cfg_wdata = d;
    tick();
    cfg_wr    = 1'b0;
  endtask

  // Starts a line, optionally writes at clock mid_k, optionally stops at stop_k.
  task automatic do_line(input bit en, input int mid_k, input logic [7:0] mid_d,
                         input int stop_k, output int first, output int width,
                         output int req0, output int bits0, output int bits_end);
    first = -1;
    width = 0;
    ttx_line_en = en;
    line_start  = 1'b1;
    tick();
    line_start  = 1'b0;
    cfg_wr      = 1'b0;
    ttx_line_en = !en;
    req0  = int'(ttx_req);
    bits0 = int'(ttx_bits);
    for (int k = 1; k <= LINE; k++) begin
      if (k == mid_k) begin
        cfg_wr    = 1'b1;
        cfg_wdata = mid_d;
      end
      tick();
      cfg_wr = 1'b0;
      if (ttx_req) begin
        if (first < 0) first = k;
        width++;
      end
      if (k == stop_k) break;
    end
    bits_end = int'(ttx_bits);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int first, width, req0, bits0, bits_end, hi;
    rst_n       = 1'b0;
    line_start  = 1'b0;
    ttx_line_en = 1'b0;
    cfg_wr      = 1'b0;
    cfg_wdata   = 8'h00;
    #1;
    repeat (4) tick();
    check("R9 req in reset", int'(ttx_req), 0);
    check("R9 bits in reset", int'(ttx_bits), 0);
    rst_n = 1'b1;
    ttx_line_en = 1'b1;
    hi = 0;
    for (int k = 0; k < 900; k++) begin
      tick();
      if (ttx_req) hi++;
    end
    check("R9 no strobe before first line start", hi, 0);
    check("R9 bits before first line start", int'(ttx_bits), 0);

    // Table walk: R1 field decode, R2 rise, R3/R4/R5 length, R6 enable.
    for (int i = 0; i < 8; i++) begin
      int r, f;
      bit en;
      r  = int'(VEC[i][8:5]);
      f  = int'(VEC[i][4:1]);
      en = VEC[i][0];
      wr({VEC[i][8:5], VEC[i][4:1]});
      do_line(en, 0, 8'h00, 0, first, width, req0, bits0, bits_end);
      if (en) begin
        check("R1 R2 rise position", first, RISE_BASE + r + 1);
        check(f == 0 ? "R5 window length" : "R4 window length", width, exp_len(r, f));
        check(f == 0 ? "R3 R5 bit count" : "R4 R7 bit count", bits_end, exp_bits(exp_len(r, f)));
      end else begin
        check("R6 disabled line strobe", width, 0);
        check("R6 disabled line bits", bits_end, 0);
      end
      check("R7 bits cleared after line start", bits0, 0);
    end

    // R8: mid-line write is deferred to the next line.
    wr(8'h00);
    do_line(1'b1, 100, 8'hF0, 0, first, width, req0, bits0, bits_end);
    check("R8 mid-line write leaves rise", first, RISE_BASE + 1);
    check("R8 mid-line write leaves length", width, WIN_CLKS);
    check("R7 bits hold after window", int'(ttx_bits), 360);
    do_line(1'b1, 0, 8'h00, 0, first, width, req0, bits0, bits_end);
    check("R8 write adopted next line rise", first, RISE_BASE + 15 + 1);
    check("R5 tracking length r=15", width, WIN_CLKS);

    // R8: write in the same cycle as line start governs that line.
    cfg_wr    = 1'b1;
    cfg_wdata = 8'h30;
    do_line(1'b1, 0, 8'h00, 0, first, width, req0, bits0, bits_end);
    check("R8 same-cycle write rise", first, RISE_BASE + 3 + 1);
    check("R8 same-cycle write length", width, WIN_CLKS);

    // R10: line start inside an open window.
    wr(8'h00);
    do_line(1'b1, 0, 8'h00, 200, first, width, req0, bits0, bits_end);
    check("R10 strobe open before restart", int'(ttx_req), 1);
    check("R7 partial bit count", bits_end, exp_bits(width - 1));
    do_line(1'b1, 0, 8'h00, 0, first, width, req0, bits0, bits_end);
    check("R10 strobe low after restart", req0, 0);
    check("R10 bits cleared by restart", bits0, 0);
    check("R10 restarted rise", first, RISE_BASE + 1);
    check("R10 R3 full window after restart", width, WIN_CLKS);
    check("R3 bits after restart", bits_end, 360);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule